// File: doc/BRIEF.md
# Multi-Mode Timer Channel

A 16-bit timer channel with a byte-wide register port, meant to be instantiated several times in a timer cluster. Software picks one of three behaviours through a mode register. As a down-counting interval timer, it counts a selected internal clock enable. As an event counter, it counts edges on an external pin or underflow pulses coming from a neighbouring channel. As a measurement unit, it counts up from zero and latches the count at each measured edge of the pin, to give a pulse period or a pulse width.

In the down-counting modes the counter reloads from a reload register when it wraps below zero. That underflow raises a one-cycle interrupt request and a one-cycle cascade pulse that a neighbouring channel can count. In measurement mode the measured edge clears the counter, copies the old count into a capture register and raises the interrupt. A counter that wraps before an edge arrives sets a sticky overflow flag. The external pin passes through a synchronizer with a parameter for its depth. The cluster's neighbour wiring is computed by a package function.

Top module: `tmb_channel`

## Requirements
- R1: After reset, irq_o and casc_o are low and every readable address (0 config, 1 control, 2 count low byte, 3 count high byte) reads 0.
- R2: The config register at address 0 holds the mode in bits [1:0] (00 interval timer, 01 event counter, 10 measurement) and the clock select in bits [7:6], which picks clk_en[0..3]. In interval timer mode each selected enable decrements the counter. A tick at count 0 reloads it instead, so underflows repeat every reload+1 ticks.
- R3: Every underflow gives exactly one cycle of irq_o and of casc_o.
- R4: Addresses 2 and 3 write the low and high bytes of the reload value. While the run bit (control bit 0) is clear, the same write also loads the counter byte. While it is set, only the reload changes. Outside measurement mode, addresses 2 and 3 read the counter.
- R5: In event counter mode with config bit 2 clear, pin edges are counted. Config bits [5:4] select the edge: 00 falling, 01 rising, 1x both.
- R6: In event counter mode with config bit 2 set, casc_i pulses are counted and the pin has no effect.
- R7: In measurement mode with config bit 3 clear (period), each rising pin edge copies the count into the capture register, clears the counter and pulses irq_o. A tick in that same cycle is dropped, so with a tick every cycle a period of P cycles captures P-1. Addresses 2 and 3 read the capture register in this mode.
- R8: With config bit 3 set (width), both pin edges capture. The value after a falling edge is high-time minus 1, and the value after a rising edge is low-time minus 1.
- R9: In measurement mode, a tick at count FFFFh sets the overflow flag (control bit 1). The flag stays set until a control write with bit 1 clear.
- R10: With mode 11, or with the run bit clear, the counter holds its value.
- R11: The cluster neighbour of channel i is i-1, except that channel 0 takes channel 2 and channel 3 takes channel 5 (tmb_neighbour).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for both read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| clk_en | input | 4 | Prescaled clock enables: fast, /8, /32, slow/32 |
| pin_i | input | 1 | External input, asynchronous |
| casc_i | input | 1 | Underflow pulse from the neighbour channel |
| casc_o | output | 1 | Underflow pulse to other channels |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
In measurement mode the edge that clears the counter and the clock tick that increments it can fall in the same cycle. The bench provokes this on every edge by holding the fastest clock enable high, so every edge coincides with a tick. Exact captures of P-1 for the period and of the high and low times minus one for the width show that the clear wins and the tick is dropped. The overflow flag's set and clear are judged through the control register after the counter is preloaded close to its top value.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

   localparam int TMB_NCLK  = 4;
   localparam int TMB_CSEL_W = $clog2(TMB_NCLK);

   typedef enum logic [1:0] {
      TMB_TIMER   = 2'd0,
      TMB_EVENT   = 2'd1,
      TMB_MEASURE = 2'd2,
      TMB_IDLE    = 2'd3
   } tmb_mode_e;

   typedef struct packed {
      logic [TMB_CSEL_W-1:0] clk_sel;
      logic [1:0]            edge_sel;
      logic                  meas_width;
      logic                  evt_casc;
      tmb_mode_e             mode;
   } tmb_cfg_t;

   // cluster wiring: channels form groups of three; the first of each
   // group takes the last of its group, the others take their predecessor
   function automatic int tmb_neighbour(input int idx);
      int base;
      base = (idx / 3) * 3;
      return (idx % 3 == 0) ? base + 2 : idx - 1;
   endfunction

endpackage

// File: rtl/tmb_edge_detect.sv
module tmb_edge_detect #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   if (SYNC_N < 2) begin : g_bad_sync
      $error("tmb_edge_detect: SYNC_N must be at least 2");
   end

   logic [SYNC_N-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_N-2:0], pin_i};
         last_q <= sync_q[SYNC_N-1];
      end
   end

   assign rise_o =  sync_q[SYNC_N-1] & ~last_q;
   assign fall_o = ~sync_q[SYNC_N-1] &  last_q;

endmodule

// File: rtl/tmb_src_sel.sv
module tmb_src_sel
   import tmb_pkg::*;
(
   input  logic [TMB_NCLK-1:0] clk_en,
   input  tmb_cfg_t            cfg,
   input  logic                rise,
   input  logic                fall,
   input  logic                casc_i,
   output logic                tick,
   output logic                meas_edge
);

   if (TMB_NCLK != (1 << TMB_CSEL_W)) begin : g_bad_nclk
      $error("tmb_src_sel: clock enable count must be a power of two");
   end

   logic int_tick;
   logic pin_evt;

   assign int_tick = clk_en[cfg.clk_sel];

   always_comb begin
      case (cfg.edge_sel)
         2'b00:   pin_evt = fall;
         2'b01:   pin_evt = rise;
         default: pin_evt = rise | fall;
      endcase
   end

   always_comb begin
      tick      = 1'b0;
      meas_edge = 1'b0;
      case (cfg.mode)
         TMB_TIMER:   tick = int_tick;
         TMB_EVENT:   tick = cfg.evt_casc ? casc_i : pin_evt;
         TMB_MEASURE: begin
            tick      = int_tick;
            meas_edge = cfg.meas_width ? (rise | fall) : rise;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/tmb_core.sv
module tmb_core
   import tmb_pkg::*;
#(
   parameter  int CNT_W  = 16,
   localparam int NBYTES = CNT_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  tmb_mode_e         mode,
   input  logic              tick,
   input  logic              meas_edge,
   input  logic [NBYTES-1:0] byte_we,
   input  logic [7:0]        wdata,
   input  logic              ovf_clr,
   output logic [CNT_W-1:0]  cnt_o,
   output logic [CNT_W-1:0]  cap_o,
   output logic              ovf_o,
   output logic              uf_o,
   output logic              cap_evt_o
);

   if (CNT_W % 8 != 0 || CNT_W < 8) begin : g_bad_width
      $error("tmb_core: CNT_W must be a non-zero multiple of 8");
   end

   logic [7:0]       reload_b [NBYTES];
   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, cap_q, cap_nxt;
   logic             ovf_q, ovf_set, uf_q, uf_nxt, evt_q, evt_nxt;

   // reload register, one lane per byte
   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          reload_b[k] <= 8'h00;
         else if (byte_we[k]) reload_b[k] <= wdata;
      end
      assign reload[k*8 +: 8] = reload_b[k];
   end

   always_comb begin
      cnt_nxt = cnt_q;
      cap_nxt = cap_q;
      uf_nxt  = 1'b0;
      evt_nxt = 1'b0;
      ovf_set = 1'b0;
      if (run) begin
         case (mode)
            TMB_TIMER, TMB_EVENT: begin
               if (tick) begin
                  if (cnt_q == '0) begin
                     cnt_nxt = reload;
                     uf_nxt  = 1'b1;
                  end else begin
                     cnt_nxt = cnt_q - 1'b1;
                  end
               end
            end
            TMB_MEASURE: begin
               if (meas_edge) begin
                  // edge wins over a tick in the same cycle
                  cap_nxt = cnt_q;
                  cnt_nxt = '0;
                  evt_nxt = 1'b1;
               end else if (tick) begin
                  ovf_set = &cnt_q;
                  cnt_nxt = cnt_q + 1'b1;
               end
            end
            default: ;
         endcase
      end else begin
         for (int k = 0; k < NBYTES; k++) begin
            if (byte_we[k]) cnt_nxt[k*8 +: 8] = wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cap_q <= '0;
         ovf_q <= 1'b0;
         uf_q  <= 1'b0;
         evt_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         cap_q <= cap_nxt;
         uf_q  <= uf_nxt;
         evt_q <= evt_nxt;
         if (ovf_set)      ovf_q <= 1'b1;
         else if (ovf_clr) ovf_q <= 1'b0;
      end
   end

   assign cnt_o     = cnt_q;
   assign cap_o     = cap_q;
   assign ovf_o     = ovf_q;
   assign uf_o      = uf_q;
   assign cap_evt_o = evt_q;

   assert_reload_on_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (mode == TMB_TIMER || mode == TMB_EVENT) && tick && cnt_q == '0)
      |=> cnt_q == $past(reload));

   assert_underflow_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      uf_q |-> ($past(cnt_q) == '0 && $past(tick) && $past(run)));

   assert_stopped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run && byte_we == '0) || (run && mode == TMB_IDLE)) |=> $stable(cnt_q));

   assert_edge_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mode == TMB_MEASURE && meas_edge)
      |=> (cap_q == $past(cnt_q) && cnt_q == '0 && evt_q));

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q);

endmodule

// File: rtl/tmb_channel.sv
module tmb_channel
   import tmb_pkg::*;
#(
   parameter  int CNT_W  = 16,
   parameter  int SYNC_N = 2,
   parameter  int ADDR_W = 2,
   localparam int NBYTES = CNT_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [7:0]          bus_wdata,
   output logic [7:0]          bus_rdata,
   input  logic [TMB_NCLK-1:0] clk_en,
   input  logic                pin_i,
   input  logic                casc_i,
   output logic                casc_o,
   output logic                irq_o
);

   localparam int LANE0 = 2;

   if (LANE0 + NBYTES > (1 << ADDR_W)) begin : g_bad_addr
      $error("tmb_channel: ADDR_W too small for the byte lanes");
   end

   tmb_cfg_t          cfg_q;
   logic              run_q;
   logic [NBYTES-1:0] byte_we;
   logic              ovf_clr;
   logic              rise, fall, tick, meas_edge;
   logic [CNT_W-1:0]  cnt, cap, view;
   logic              ovf, uf, cap_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= tmb_cfg_t'(8'h00);
         run_q <= 1'b0;
      end else if (bus_we) begin
         if (bus_addr == ADDR_W'(0)) cfg_q <= tmb_cfg_t'(bus_wdata);
         if (bus_addr == ADDR_W'(1)) run_q <= bus_wdata[0];
      end
   end

   assign ovf_clr = bus_we && bus_addr == ADDR_W'(1) && !bus_wdata[1];

   for (genvar k = 0; k < NBYTES; k++) begin : g_we
      assign byte_we[k] = bus_we && bus_addr == ADDR_W'(LANE0 + k);
   end

   tmb_edge_detect #(.SYNC_N(SYNC_N)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   tmb_src_sel u_src (
      .clk_en    (clk_en),
      .cfg       (cfg_q),
      .rise      (rise),
      .fall      (fall),
      .casc_i    (casc_i),
      .tick      (tick),
      .meas_edge (meas_edge)
   );

   tmb_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_q),
      .mode      (cfg_q.mode),
      .tick      (tick),
      .meas_edge (meas_edge),
      .byte_we   (byte_we),
      .wdata     (bus_wdata),
      .ovf_clr   (ovf_clr),
      .cnt_o     (cnt),
      .cap_o     (cap),
      .ovf_o     (ovf),
      .uf_o      (uf),
      .cap_evt_o (cap_evt)
   );

   assign view = (cfg_q.mode == TMB_MEASURE) ? cap : cnt;

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_addr == ADDR_W'(0)) bus_rdata = cfg_q;
      if (bus_addr == ADDR_W'(1)) bus_rdata = {6'b0, ovf, run_q};
      for (int k = 0; k < NBYTES; k++) begin
         if (bus_addr == ADDR_W'(LANE0 + k)) bus_rdata = view[k*8 +: 8];
      end
   end

   assign casc_o = uf;
   assign irq_o  = uf | cap_evt;

   assert_irq_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(run_q));

endmodule

// File: tb/test_tmb_channel.sv
module test_tmb_channel;
   import tmb_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [3:0] clk_en = 4'h0;
   logic       pin_i = 1'b0;
   logic       casc_i = 1'b0;
   logic       casc_o, irq_o;

   int checks = 0;
   int fails = 0;
   int irq_cnt = 0;
   int casc_cnt = 0;
   bit f1_on = 1'b0;
   bit done = 1'b0;
   int div = 0;

   always #5 clk = ~clk;

   tmb_channel i_tmb_channel (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en),
      .pin_i(pin_i), .casc_i(casc_i), .casc_o(casc_o), .irq_o(irq_o)
   );

   // prescaled enables: one-cycle pulses every 8 and every 32 cycles
   initial begin
      forever begin
         @(negedge clk);
         div++;
         clk_en[0] = f1_on;
         clk_en[1] = (div % 8 == 0);
         clk_en[2] = (div % 32 == 0);
         clk_en[3] = (div % 32 == 16);
      end
   end

   always @(posedge clk) begin
      irq_cnt  <= irq_cnt + int'(irq_o);
      casc_cnt <= casc_cnt + int'(casc_o);
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr  = 2'(a);
      bus_wdata = 8'(d);
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      bus_addr = 2'(a);
      #1 v = int'(bus_rdata);
   endtask

   task automatic setup(input int cfg, input int rl);
      wr(1, 0);
      wr(0, cfg);
      wr(2, rl & 8'hFF);
      wr(3, rl >> 8);
   endtask

   task automatic wait_irq();
      do @(negedge clk); while (!irq_o);
   endtask

   task automatic t_reset();
      int v;
      check("R1 irq", int'(irq_o), 0);
      check("R1 casc", int'(casc_o), 0);
      for (int a = 0; a < 4; a++) begin
         rd(a, v);
         check("R1 read", v, 0);
      end
   endtask

   task automatic t_neighbour();
      int exp [6] = '{2, 0, 1, 5, 3, 4};
      for (int i = 0; i < 6; i++) check("R11 neighbour", tmb_neighbour(i), exp[i]);
   endtask

   task automatic t_stopped_load();
      int v;
      f1_on = 1'b0;
      setup(8'h00, 16'h1234);
      rd(2, v); check("R4 stopped load lo", v, 8'h34);
      rd(3, v); check("R4 stopped load hi", v, 8'h12);
      wr(1, 1);
      wr(2, 8'h55);
      wr(3, 8'h00);
      rd(2, v); check("R4 running write lo", v, 8'h34);
      rd(3, v); check("R4 running write hi", v, 8'h12);
      wr(1, 0);
   endtask

   task automatic t_timer(input int cfg, input int rl, input bit fast,
                          input int cycles, input int exp, input string tag);
      int i0, c0;
      setup(cfg, rl);
      f1_on = fast;
      wr(1, 1);
      @(negedge clk);
      i0 = irq_cnt; c0 = casc_cnt;
      repeat (cycles) @(negedge clk);
      check({tag, " irq"}, irq_cnt - i0, exp);
      check("R3 casc count", casc_cnt - c0, exp);
      wr(1, 0);
      f1_on = 1'b0;
   endtask

   task automatic t_event_pin(input int cfg, input int exp, input string tag);
      int i0;
      setup(cfg, 2);
      wr(1, 1);
      i0 = irq_cnt;
      for (int n = 0; n < 9; n++) begin
         @(negedge clk) pin_i = 1'b1;
         repeat (4) @(negedge clk);
         pin_i = 1'b0;
         repeat (4) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      check(tag, irq_cnt - i0, exp);
      wr(1, 0);
   endtask

   task automatic t_event_casc();
      int i0;
      setup(8'h05, 1);
      wr(1, 1);
      i0 = irq_cnt;
      for (int n = 0; n < 6; n++) begin
         @(negedge clk) casc_i = 1'b1; pin_i = ~pin_i;
         @(negedge clk) casc_i = 1'b0;
         repeat (3) @(negedge clk);
         pin_i = ~pin_i;
      end
      repeat (6) @(negedge clk);
      check("R6 cascade count, pin ignored", irq_cnt - i0, 3);
      wr(1, 0);
      pin_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_period();
      int lo, hi;
      setup(8'h02, 0);
      f1_on = 1'b1;
      wr(1, 1);
      fork
         for (int n = 0; n < 5; n++) begin
            @(negedge clk) pin_i = 1'b1;
            repeat (10) @(negedge clk);
            pin_i = 1'b0;
            repeat (9) @(negedge clk);
         end
         begin
            repeat (3) wait_irq();
            rd(2, lo); rd(3, hi);
            check("R7 period capture", hi * 256 + lo, 19);
         end
      join
      wr(1, 0);
      f1_on = 1'b0;
   endtask

   task automatic t_width();
      int lo, hi, lvl;
      setup(8'h0A, 0);
      f1_on = 1'b1;
      wr(1, 1);
      fork
         for (int n = 0; n < 6; n++) begin
            @(negedge clk) pin_i = 1'b1;
            repeat (9) @(negedge clk);
            pin_i = 1'b0;
            repeat (14) @(negedge clk);
         end
         begin
            repeat (2) wait_irq();
            for (int m = 0; m < 2; m++) begin
               wait_irq();
               lvl = int'(pin_i);
               rd(2, lo); rd(3, hi);
               check("R8 width capture", hi * 256 + lo, lvl ? 14 : 8);
            end
         end
      join
      wr(1, 0);
      f1_on = 1'b0;
   endtask

   task automatic t_overflow();
      int v;
      setup(8'h02, 16'hFFF0);
      f1_on = 1'b1;
      wr(1, 1);
      repeat (30) @(negedge clk);
      rd(1, v); check("R9 overflow set", v, 3);
      repeat (10) @(negedge clk);
      rd(1, v); check("R9 overflow sticky", v, 3);
      wr(1, 1);
      rd(1, v); check("R9 overflow cleared", v, 1);
      wr(1, 0);
      f1_on = 1'b0;
   endtask

   task automatic t_idle();
      int a, b;
      setup(8'h03, 16'h0ABC);
      f1_on = 1'b1;
      wr(1, 1);
      rd(2, a);
      repeat (10) @(negedge clk);
      rd(2, b);
      check("R10 idle mode hold", b, a);
      check("R10 idle mode value", b, 8'hBC);
      wr(1, 0);
      f1_on = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_neighbour();
      t_stopped_load();
      t_timer(8'h00, 3, 1'b1, 40, 10, "R2 timer fast");
      t_timer(8'h40, 1, 1'b0, 160, 10, "R2 timer div8");
      t_timer(8'hC0, 0, 1'b0, 320, 10, "R2 timer slow reload0");
      t_event_pin(8'h11, 3, "R5 rising edges");
      t_event_pin(8'h01, 3, "R5 falling edges");
      t_event_pin(8'h21, 6, "R5 both edges");
      t_event_casc();
      t_period();
      t_width();
      t_overflow();
      t_idle();
      finish_run();
   end

endmodule